// File: doc/BRIEF.md
# Programmable Letter Substitution Table

This block is a small programmable lookup table that maps a letter code in the range 0 to 25 onto another letter code. It sits in the signal path of a letter-scrambling datapath at the point where a character enters and later leaves the rotor section. On the way in, a character is looked up using the forward-path input. On the way back, it is looked up using the return-path input. One registered result comes out one cycle after each read request.

Each of the 26 entries is 5 bits wide. After reset the table holds the identity mapping. A write takes two phases on one shared data bus. The first phase captures the target index into an internal address register. The second phase commits the data word through a decoded one-of-26 word enable. Every entry maps in one direction only. Pairing two letters in both directions therefore takes two write sequences. A bypass mode returns the selected input unchanged, which lets setting values pass straight through while other parts of the datapath are being configured.

Top module: `plug_table`

## Requirements
- R1: After reset every entry k holds the value k, rd_out is 0 and rd_valid is 0.
- R2: When wr_addr_en is high at a clock edge, wr_data is captured as the write address. The capture by itself changes no table entry.
- R3: When wr_data_en is high at a clock edge, wr_data is stored into the entry at the captured address and all other entries keep their values. The captured address is retained, so a second data strobe writes to the same entry again.
- R4: Writing entry a with value b leaves entry b unchanged, so each mapping holds in one direction only.
- R5: When rd_en is high with rd_dir=0 and bypass=0, rd_out in the next cycle equals the entry indexed by fwd_in.
- R6: When rd_en is high with rd_dir=1 and bypass=0, rd_out in the next cycle equals the entry indexed by ret_in.
- R7: When rd_en is high with bypass=1, rd_out in the next cycle equals the selected input unchanged, where rd_dir=0 selects fwd_in and rd_dir=1 selects ret_in. Bypass reads do not alter the table.
- R8: A data strobe while the captured address is 26 or higher writes no entry.
- R9: A non-bypass read whose selected address is 26 or higher returns 0.
- R10: rd_valid is high in exactly the cycle after each cycle in which rd_en is high. While rd_en is low, rd_out holds its value.
- R11: A read in the same cycle as a data strobe to the same entry returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 5 | Shared bus for the write address and the write data |
| wr_addr_en | input | 1 | Captures wr_data as the write address |
| wr_data_en | input | 1 | Commits wr_data into the addressed entry |
| rd_en | input | 1 | Read request |
| rd_dir | input | 1 | Read address select: 0 selects fwd_in, 1 selects ret_in |
| bypass | input | 1 | Return the selected input instead of the table entry |
| fwd_in | input | 5 | Forward-path read address |
| ret_in | input | 5 | Return-path read address |
| rd_out | output | 5 | Registered read result |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
The assertions assume that wr_addr_en and wr_data_en are never high in the same cycle. They also assume that the controller holds wr_data for one cycle after the data strobe falls. The bench write task always uses three separate cycles: address, data, then hold, with no overlapping strobes. Read addresses and captured write addresses range over the full 5-bit code, so that the out-of-range handling for codes 26 to 31 is exercised as ordinary stimulus.

// File: rtl/plug_pkg.sv
package plug_pkg;
  localparam int unsigned LETTERS_DEF = 26;
  localparam int unsigned CODE_W_DEF  = 5;
endpackage

// File: rtl/plug_wr_decode.sv
module plug_wr_decode #(
  parameter int unsigned LETTERS = plug_pkg::LETTERS_DEF,
  parameter int unsigned CODE_W  = plug_pkg::CODE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  wr_data,
  input  logic               wr_addr_en,
  input  logic               wr_data_en,
  output logic [LETTERS-1:0] word_en
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(LETTERS - 1);

  logic [CODE_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (wr_addr_en) addr_q <= wr_data;
  end

  for (genvar i = 0; i < LETTERS; i++) begin : g_wl
    assign word_en[i] = wr_data_en && (addr_q == CODE_W'(i));
  end

  // at most one word line per strobe
  assert_onehot_wl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(word_en));
  // out-of-range address drives no word line
  assert_no_oob_write_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_q > LAST) |-> (word_en == '0));
  // without a data strobe nothing is written
  assert_idle_wl_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_data_en |-> (word_en == '0));
endmodule

// File: rtl/plug_store.sv
module plug_store #(
  parameter int unsigned LETTERS = plug_pkg::LETTERS_DEF,
  parameter int unsigned CODE_W  = plug_pkg::CODE_W_DEF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [LETTERS-1:0]             word_en,
  input  logic [CODE_W-1:0]              wr_data,
  output logic [LETTERS-1:0][CODE_W-1:0] entries
);
  for (genvar i = 0; i < LETTERS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) entries[i] <= CODE_W'(i);
      else if (word_en[i]) entries[i] <= wr_data;
    end
    // an entry changes only when its word line fired
    assert_entry_stable_R3: assert property (@(posedge clk) disable iff (rst)
      !word_en[i] |=> $stable(entries[i]));
  end
endmodule

// File: rtl/plug_read.sv
module plug_read #(
  parameter int unsigned LETTERS = plug_pkg::LETTERS_DEF,
  parameter int unsigned CODE_W  = plug_pkg::CODE_W_DEF
) (
  input  logic [LETTERS-1:0][CODE_W-1:0] entries,
  input  logic                           rd_dir,
  input  logic                           bypass,
  input  logic [CODE_W-1:0]              fwd_in,
  input  logic [CODE_W-1:0]              ret_in,
  output logic [CODE_W-1:0]              result
);
  logic [CODE_W-1:0] sel;
  logic [CODE_W-1:0] looked_up;

  assign sel = rd_dir ? ret_in : fwd_in;

  always_comb begin
    looked_up = '0;
    for (int i = 0; i < int'(LETTERS); i++) begin
      if (sel == CODE_W'(i)) looked_up = entries[i];
    end
  end

  assign result = bypass ? sel : looked_up;
endmodule

// File: rtl/plug_table.sv
module plug_table #(
  parameter int unsigned LETTERS = plug_pkg::LETTERS_DEF,
  parameter int unsigned CODE_W  = plug_pkg::CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              wr_addr_en,
  input  logic              wr_data_en,
  input  logic              rd_en,
  input  logic              rd_dir,
  input  logic              bypass,
  input  logic [CODE_W-1:0] fwd_in,
  input  logic [CODE_W-1:0] ret_in,
  output logic [CODE_W-1:0] rd_out,
  output logic              rd_valid
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(LETTERS - 1);

  logic [LETTERS-1:0]             word_en;
  logic [LETTERS-1:0][CODE_W-1:0] entries;
  logic [CODE_W-1:0]              result;

  plug_wr_decode #(.LETTERS(LETTERS), .CODE_W(CODE_W)) u_dec (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_addr_en(wr_addr_en),
    .wr_data_en(wr_data_en), .word_en(word_en));

  plug_store #(.LETTERS(LETTERS), .CODE_W(CODE_W)) u_store (
    .clk(clk), .rst(rst), .word_en(word_en), .wr_data(wr_data),
    .entries(entries));

  plug_read #(.LETTERS(LETTERS), .CODE_W(CODE_W)) u_rd (
    .entries(entries), .rd_dir(rd_dir), .bypass(bypass),
    .fwd_in(fwd_in), .ret_in(ret_in), .result(result));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_out   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_out <= result;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_valid_low_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_out));
  assert_bypass_passes_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bypass) |=> (rd_out == $past(rd_dir ? ret_in : fwd_in)));
  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bypass && ((rd_dir ? ret_in : fwd_in) > LAST)) |=> (rd_out == '0));
endmodule

// File: tb/sim_plug_table.sv
module sim_plug_table;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] wr_data = '0;
  logic       wr_addr_en = 1'b0, wr_data_en = 1'b0;
  logic       rd_en = 1'b0, rd_dir = 1'b0, bypass = 1'b0;
  logic [4:0] fwd_in = '0, ret_in = '0;
  logic [4:0] rd_out;
  logic       rd_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] model [26];

  always #5 clk = ~clk;

  plug_table u0 (.clk(clk), .rst(rst), .wr_data(wr_data), .wr_addr_en(wr_addr_en),
    .wr_data_en(wr_data_en), .rd_en(rd_en), .rd_dir(rd_dir), .bypass(bypass),
    .fwd_in(fwd_in), .ret_in(ret_in), .rd_out(rd_out), .rd_valid(rd_valid));

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_read(bit dir, bit byp, logic [4:0] f, logic [4:0] r);
    logic [4:0] s = dir ? r : f;
    if (byp) return s;
    if (s > 5'd25) return 5'd0;
    return model[s];
  endfunction

  task automatic do_write(logic [4:0] a, logic [4:0] d);
    @(negedge clk); wr_data = a; wr_addr_en = 1;
    @(negedge clk); wr_addr_en = 0; wr_data = d; wr_data_en = 1;
    @(negedge clk); wr_data_en = 0;
    if (a <= 5'd25) model[a] = d;
  endtask

  task automatic do_read(string req, bit dir, bit byp, logic [4:0] f, logic [4:0] r);
    logic [4:0] e;
    @(negedge clk); rd_en = 1; rd_dir = dir; bypass = byp; fwd_in = f; ret_in = r;
    e = expect_read(dir, byp, f, r);
    @(negedge clk); rd_en = 0;
    check(req, rd_out, e);
    check("R10 valid", {4'd0, rd_valid}, 5'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] hold;
    void'($urandom(32'd4242));
    for (int k = 0; k < 26; k++) model[k] = 5'(k);
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 rd_out", rd_out, 5'd0);
    check("R1 rd_valid", {4'd0, rd_valid}, 5'd0);
    for (int k = 0; k < 26; k++) do_read("R1 identity", 0, 0, 5'(k), 5'd0);

    // R2: address capture alone writes nothing
    @(negedge clk); wr_data = 5'd3; wr_addr_en = 1;
    @(negedge clk); wr_addr_en = 0;
    do_read("R2 capture no write", 0, 0, 5'd3, 5'd0);

    // R3 and R4
    do_write(5'd0, 5'd1);
    do_read("R3 commit", 0, 0, 5'd0, 5'd0);
    do_read("R4 one direction", 1, 0, 5'd0, 5'd1);
    do_read("R3 neighbour untouched", 0, 0, 5'd2, 5'd0);
    // R3 retained address: second strobe hits entry 0 again
    @(negedge clk); wr_data = 5'd9; wr_data_en = 1;
    @(negedge clk); wr_data_en = 0; model[0] = 5'd9;
    do_read("R3 retained address", 0, 0, 5'd0, 5'd0);

    // R5 / R6 direction select with conflicting inputs
    do_write(5'd7, 5'd20);
    do_read("R5 forward", 0, 0, 5'd7, 5'd8);
    do_read("R6 return", 1, 0, 5'd8, 5'd7);

    // R7 bypass
    do_read("R7 bypass fwd", 0, 1, 5'd7, 5'd2);
    do_read("R7 bypass ret", 1, 1, 5'd7, 5'd30);
    do_read("R7 table intact", 0, 0, 5'd7, 5'd0);

    // R8 out-of-range write
    do_write(5'd27, 5'd4);
    for (int k = 0; k < 26; k++) do_read("R8 oob write", 0, 0, 5'(k), 5'd0);

    // R9 out-of-range read
    do_read("R9 oob fwd", 0, 0, 5'd26, 5'd0);
    do_read("R9 oob ret", 1, 0, 5'd0, 5'd31);

    // R10 hold while idle
    do_read("R10 setup", 0, 0, 5'd7, 5'd0);
    hold = rd_out;
    @(negedge clk); fwd_in = 5'd1; ret_in = 5'd2;
    @(negedge clk);
    check("R10 hold", rd_out, hold);
    check("R10 valid low", {4'd0, rd_valid}, 5'd0);

    // R11 read during write returns old value
    @(negedge clk); wr_data = 5'd12; wr_addr_en = 1;
    @(negedge clk); wr_addr_en = 0; wr_data = 5'd5; wr_data_en = 1;
    rd_en = 1; rd_dir = 0; bypass = 0; fwd_in = 5'd12;
    @(negedge clk); wr_data_en = 0; rd_en = 0;
    check("R11 old value", rd_out, model[12]);
    model[12] = 5'd5;
    do_read("R11 new value", 0, 0, 5'd12, 5'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0)
        do_write(5'($urandom_range(0, 31)), 5'($urandom_range(0, 25)));
      else
        do_read("R5 R6 R7 R9 random", 1'($urandom_range(0, 1)),
                $urandom_range(0, 7) == 0, 5'($urandom_range(0, 31)),
                5'($urandom_range(0, 31)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule